// File: doc/BRIEF.md
# Pulse-Width Sensor Frame Decoder

This block turns a buffer of captured line edges into one 40-bit sensor reading. Each buffer entry holds a timestamp in nanoseconds and the line level that followed the edge. After a start strobe, the block computes the first candidate position in the buffer from the number of captured edges. For each bit it measures how long the line stayed high and slices that time against a fixed threshold. It then checks the five resulting bytes with an additive checksum and converts them to signed temperature and humidity values in thousandths of a unit.

A noisy or truncated capture can shift the frame inside the buffer. When a candidate position fails, the block moves one entry earlier and tries again, until a position decodes cleanly or none are left. Two sensor data layouts are supported: a 16-bit signed-magnitude layout and an 8-bit integer layout. The first byte of the frame selects between them. The edge capture logic owns the buffer and serves two combinational read ports.

Top module: `edge_frame_decoder`

## Requirements
- R1: After reset, done_o and err_o are low and temp_o and hum_o are zero.
- R2: A start is taken only while the block is not decoding. The first offset tried is edge_cnt_i + 2 - 83, with edge_cnt_i clamped to 83. If that offset is negative (edge_cnt_i below 81), err_o is high on the cycle after the start.
- R3: Bit i at offset k reads entries k+2i+1 (port A) and k+2i+2 (port B). If the level at entry k+2i+1 is low, offset k is abandoned at once and k-1 is tried, starting again from bit 0.
- R4: A bit is 1 when the port B timestamp minus the port A timestamp is strictly greater than 49000 ns, and 0 otherwise (49000 decodes as 0, 49001 as 1).
- R5: The 40 bits are packed MSB first into five bytes, in this order: humidity high, humidity low, temperature high, temperature low, checksum.
- R6: An offset is accepted only if the low 8 bits of the sum of the first four bytes equal the checksum byte; otherwise the next lower offset is tried.
- R7: If the humidity high byte is below 4, hum_o = {hum_hi,hum_lo}*100. temp_o = {temp_hi[6:0],temp_lo}*100, negated when temp_hi[7] is 1.
- R8: If the humidity high byte is 4 or more and both low bytes are zero, temp_o = temp_hi*1000 and hum_o = hum_hi*1000.
- R9: Any other byte combination fails the offset in the same way as a checksum mismatch. Once offset 0 has failed, err_o rises.
- R10: When the first offset succeeds, done_o rises 42 cycles after the start edge. done_o or err_o, together with temp_o and hum_o, then hold until the next start.
- R11: done_o and err_o are never high together, and a start clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for one decode |
| edge_cnt_i | input | CNT_W | Number of edges captured in the buffer |
| rd_a_addr_o | output | ADDR_W | Buffer address of the rising edge of the current bit |
| rd_a_ts_i | input | TS_W | Timestamp at rd_a_addr_o |
| rd_a_lvl_i | input | 1 | Line level stored at rd_a_addr_o |
| rd_b_addr_o | output | ADDR_W | Buffer address of the falling edge of the current bit |
| rd_b_ts_i | input | TS_W | Timestamp at rd_b_addr_o |
| temp_o | output | OUT_W | Signed temperature, thousandths of a degree |
| hum_o | output | OUT_W | Signed humidity, thousandths of a percent |
| done_o | output | 1 | Decode succeeded; results valid |
| err_o | output | 1 | No offset decoded |

## Verification
The latency of every result follows from the retry path. A first-offset success reports done 42 cycles after the start edge. A failed sync on bit 0 adds one cycle. A full frame rejected by its checksum adds 41 cycles. A negative start offset reports err on the first cycle. A single offset that fails at the checksum or format stage reports err after 41 cycles. The bench counts clock edges from the start edge, samples on the falling edge, and compares the cycle on which done or err first appears with these counts. The output values are read on that cycle and again after the buffer has been overwritten.

// File: rtl/edf_pkg.sv
package edf_pkg;
  localparam int FRAME_BITS = 40;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_CONVERT,
    ST_DONE,
    ST_ERR
  } edf_state_e;

  typedef struct packed {
    logic [7:0] hum_hi;
    logic [7:0] hum_lo;
    logic [7:0] tmp_hi;
    logic [7:0] tmp_lo;
    logic [7:0] csum;
  } edf_frame_t;
endpackage

// File: rtl/edf_bit_slicer.sv
module edf_bit_slicer #(
  parameter int TS_W      = 32,
  parameter int THRESH_NS = 49000
) (
  input  logic [TS_W-1:0] ts_rise_i,
  input  logic [TS_W-1:0] ts_fall_i,
  input  logic            lvl_rise_i,
  output logic            bit_o,
  output logic            sync_ok_o
);
  logic [TS_W-1:0] high_time;

  // modular difference tolerates timestamp wrap
  assign high_time = ts_fall_i - ts_rise_i;
  assign bit_o     = high_time > TS_W'(THRESH_NS);
  assign sync_ok_o = lvl_rise_i;
endmodule

// File: rtl/edf_frame_check.sv
module edf_frame_check
  import edf_pkg::*;
(
  input  edf_frame_t frame_i,
  output logic       csum_ok_o
);
  logic [7:0] sum;

  always_comb begin
    sum = frame_i.hum_hi + frame_i.hum_lo + frame_i.tmp_hi + frame_i.tmp_lo;
    csum_ok_o = (sum == frame_i.csum);
  end
endmodule

// File: rtl/edf_convert.sv
module edf_convert
  import edf_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  edf_frame_t              frame_i,
  output logic                    fmt_ok_o,
  output logic signed [OUT_W-1:0] temp_o,
  output logic signed [OUT_W-1:0] hum_o
);
  localparam int WIDE_SCALE   = 100;
  localparam int NARROW_SCALE = 1000;
  localparam int WIDE_HUM_MAX = 4;

  logic                    wide_fmt, narrow_fmt;
  logic [OUT_W-1:0]        hum_raw, tmp_mag;
  logic signed [OUT_W-1:0] tmp_wide;

  assign wide_fmt   = frame_i.hum_hi < 8'(WIDE_HUM_MAX);
  assign narrow_fmt = !wide_fmt && (frame_i.hum_lo == 8'd0) && (frame_i.tmp_lo == 8'd0);
  assign fmt_ok_o   = wide_fmt || narrow_fmt;

  always_comb begin
    hum_raw  = OUT_W'({frame_i.hum_hi, frame_i.hum_lo}) * OUT_W'(WIDE_SCALE);
    tmp_mag  = OUT_W'({frame_i.tmp_hi[6:0], frame_i.tmp_lo}) * OUT_W'(WIDE_SCALE);
    tmp_wide = frame_i.tmp_hi[7] ? -$signed(tmp_mag) : $signed(tmp_mag);
    if (wide_fmt) begin
      hum_o  = $signed(hum_raw);
      temp_o = tmp_wide;
    end else begin
      hum_o  = $signed(OUT_W'(frame_i.hum_hi) * OUT_W'(NARROW_SCALE));
      temp_o = $signed(OUT_W'(frame_i.tmp_hi) * OUT_W'(NARROW_SCALE));
    end
  end
endmodule

// File: rtl/edge_frame_decoder.sv
module edge_frame_decoder
  import edf_pkg::*;
#(
  parameter  int TS_W      = 32,
  parameter  int THRESH_NS = 49000,
  parameter  int PREAMBLE  = 2,
  parameter  int OUT_W     = 32,
  localparam int DEPTH     = 2 * FRAME_BITS + PREAMBLE + 1,
  localparam int ADDR_W    = $clog2(DEPTH),
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [CNT_W-1:0]        edge_cnt_i,
  output logic [ADDR_W-1:0]       rd_a_addr_o,
  input  logic [TS_W-1:0]         rd_a_ts_i,
  input  logic                    rd_a_lvl_i,
  output logic [ADDR_W-1:0]       rd_b_addr_o,
  input  logic [TS_W-1:0]         rd_b_ts_i,
  output logic signed [OUT_W-1:0] temp_o,
  output logic signed [OUT_W-1:0] hum_o,
  output logic                    done_o,
  output logic                    err_o
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam int OFF_W = CNT_W + 1;

  edf_state_e              state_q;
  logic [OFF_W-1:0]        off_q;
  logic [IDX_W-1:0]        idx_q;
  logic [FRAME_BITS-1:0]   frame_q;
  logic signed [OUT_W-1:0] temp_q, hum_q;

  logic [CNT_W-1:0]        cnt_eff;
  logic [OFF_W-1:0]        start_off, addr_rise;
  logic                    accept, last_bit;
  logic                    cur_bit, sync_ok, csum_ok, fmt_ok;
  logic signed [OUT_W-1:0] conv_temp, conv_hum;

  assign cnt_eff   = (edge_cnt_i > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : edge_cnt_i;
  assign start_off = OFF_W'(cnt_eff) + OFF_W'(PREAMBLE) - OFF_W'(DEPTH);
  assign accept    = start_i && (state_q == ST_IDLE || state_q == ST_DONE || state_q == ST_ERR);
  assign last_bit  = (idx_q == IDX_W'(FRAME_BITS - 1));

  assign addr_rise   = off_q + OFF_W'({idx_q, 1'b0}) + OFF_W'(1);
  assign rd_a_addr_o = addr_rise[ADDR_W-1:0];
  assign rd_b_addr_o = ADDR_W'(addr_rise + OFF_W'(1));

  edf_bit_slicer #(
    .TS_W     (TS_W),
    .THRESH_NS(THRESH_NS)
  ) u_slicer (
    .ts_rise_i (rd_a_ts_i),
    .ts_fall_i (rd_b_ts_i),
    .lvl_rise_i(rd_a_lvl_i),
    .bit_o     (cur_bit),
    .sync_ok_o (sync_ok)
  );

  edf_frame_check u_check (
    .frame_i  (edf_frame_t'(frame_q)),
    .csum_ok_o(csum_ok)
  );

  edf_convert #(
    .OUT_W(OUT_W)
  ) u_convert (
    .frame_i (edf_frame_t'(frame_q)),
    .fmt_ok_o(fmt_ok),
    .temp_o  (conv_temp),
    .hum_o   (conv_hum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      off_q   <= '0;
      idx_q   <= '0;
      frame_q <= '0;
      temp_q  <= '0;
      hum_q   <= '0;
    end else if (accept) begin
      idx_q <= '0;
      if (start_off[OFF_W-1]) begin
        state_q <= ST_ERR;
      end else begin
        off_q   <= start_off;
        state_q <= ST_FETCH;
      end
    end else begin
      unique case (state_q)
        ST_FETCH: begin
          if (!sync_ok) begin
            // step back one entry, restart at bit 0
            if (off_q == '0) state_q <= ST_ERR;
            else begin
              off_q   <= off_q - OFF_W'(1);
              idx_q   <= '0;
              state_q <= ST_FETCH;
            end
          end else begin
            frame_q <= {frame_q[FRAME_BITS-2:0], cur_bit};
            if (last_bit) state_q <= ST_CHECK;
            else          idx_q   <= idx_q + IDX_W'(1);
          end
        end
        ST_CHECK: begin
          if (csum_ok && fmt_ok) state_q <= ST_CONVERT;
          else if (off_q == '0) state_q <= ST_ERR;
          else begin
            off_q   <= off_q - OFF_W'(1);
            idx_q   <= '0;
            state_q <= ST_FETCH;
          end
        end
        ST_CONVERT: begin
          temp_q  <= conv_temp;
          hum_q   <= conv_hum;
          state_q <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  assign temp_o = temp_q;
  assign hum_o  = hum_q;
  assign done_o = (state_q == ST_DONE);
  assign err_o  = (state_q == ST_ERR);
endmodule

// File: rtl/edf_checker.sv
module edf_checker
  import edf_pkg::*;
#(
  parameter int DEPTH    = 83,
  parameter int PREAMBLE = 2,
  parameter int CNT_W    = 7,
  parameter int ADDR_W   = 7,
  parameter int OUT_W    = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic [CNT_W-1:0]        edge_cnt_i,
  input logic [ADDR_W-1:0]       rd_b_addr_o,
  input logic signed [OUT_W-1:0] temp_o,
  input logic signed [OUT_W-1:0] hum_o,
  input logic                    done_o,
  input logic                    err_o,
  input edf_state_e              state_q
);
  logic busy;
  assign busy = (state_q == ST_FETCH) || (state_q == ST_CHECK) || (state_q == ST_CONVERT);

  AST_DONE_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R11

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(temp_o) && $stable(hum_o))); // R10

  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> (err_o && !done_o)); // R10

  AST_SHORT_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy && (edge_cnt_i < CNT_W'(DEPTH - PREAMBLE))) |=> err_o); // R2

  AST_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (rd_b_addr_o < ADDR_W'(DEPTH))); // R3

  AST_HUM_NONNEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !hum_o[OUT_W-1]); // R7
endmodule

bind edge_frame_decoder edf_checker #(
  .DEPTH   (DEPTH),
  .PREAMBLE(PREAMBLE),
  .CNT_W   (CNT_W),
  .ADDR_W  (ADDR_W),
  .OUT_W   (OUT_W)
) u_edf_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .edge_cnt_i (edge_cnt_i),
  .rd_b_addr_o(rd_b_addr_o),
  .temp_o     (temp_o),
  .hum_o      (hum_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .state_q    (state_q)
);

// File: tb/edge_frame_decoder_bench.sv
module edge_frame_decoder_bench;
  localparam int DEPTH  = 83;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = 7;
  localparam int TS_W   = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] edge_cnt = '0;
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic [TS_W-1:0] a_ts, b_ts;
  logic a_lvl;
  logic signed [31:0] temp, hum;
  logic done, err;

  logic [TS_W-1:0] mem_ts [DEPTH];
  logic            mem_lv [DEPTH];

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  assign a_ts  = (a_addr < ADDR_W'(DEPTH)) ? mem_ts[a_addr] : '0;
  assign a_lvl = (a_addr < ADDR_W'(DEPTH)) ? mem_lv[a_addr] : 1'b0;
  assign b_ts  = (b_addr < ADDR_W'(DEPTH)) ? mem_ts[b_addr] : '0;

  edge_frame_decoder u_edge_frame_decoder (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .edge_cnt_i(edge_cnt),
    .rd_a_addr_o(a_addr), .rd_a_ts_i(a_ts), .rd_a_lvl_i(a_lvl),
    .rd_b_addr_o(b_addr), .rd_b_ts_i(b_ts),
    .temp_o(temp), .hum_o(hum), .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic [39:0] mk(input [7:0] a, b, c, d);
    logic [7:0] s;
    s = a + b + c + d;
    return {a, b, c, d, s};
  endfunction

  // odd entries are rising edges; frame bit j high time sits at entry off+2j+1
  task automatic fill(input logic [39:0] frame, input int off, input int one_ns, input int zero_ns);
    logic [TS_W-1:0] t;
    t = 32'd1000;
    for (int e = 0; e < DEPTH; e++) begin
      if (e > 0) begin
        if ((e - 1) % 2 == 1) begin
          int j;
          j = (e - 1 - off - 1) / 2;
          if ((e - 1) >= off + 1 && j < 40) t = t + TS_W'(frame[39-j] ? one_ns : zero_ns);
          else t = t + 32'd80000;
        end else begin
          t = t + 32'd50000;
        end
      end
      mem_ts[e] = t;
      mem_lv[e] = e[0];
    end
  endtask

  // returns cycles after start edge at which done or err first seen
  task automatic run(input int cnt, output int n, output bit got_done);
    @(negedge clk);
    start = 1'b1;
    edge_cnt = CNT_W'(cnt);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && !err && n < 300) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    got_done = done;
  endtask

  task automatic t_reset();
    chk(!done && !err, "R1", "done/err after reset", {done, err}, 0);
    chk(temp == 0, "R1", "temp after reset", temp, 0);
    chk(hum == 0, "R1", "hum after reset", hum, 0);
  endtask

  task automatic t_wide_pos();
    int n; bit d;
    fill(mk(8'h03, 8'hE8, 8'h00, 8'hFA), 0, 70000, 26000);
    run(81, n, d);
    chk(d, "R10", "wide positive done", d, 1);
    chk(n == 42, "R10", "latency first offset", n, 42);
    chk(hum == 100000, "R7", "hum boundary byte 3", hum, 100000);
    chk(temp == 25000, "R5", "temp byte order", temp, 25000);
  endtask

  task automatic t_wide_neg();
    int n; bit d;
    fill(mk(8'h01, 8'hF4, 8'h80, 8'h65), 0, 70000, 26000);
    run(81, n, d);
    chk(d, "R7", "wide negative done", d, 1);
    chk(temp == -10100, "R7", "negative temp", temp, -10100);
    chk(hum == 50000, "R7", "hum", hum, 50000);
  endtask

  task automatic t_narrow_hold();
    int n; bit d;
    fill(mk(8'h2D, 8'h00, 8'h17, 8'h00), 0, 70000, 26000);
    run(81, n, d);
    chk(d, "R8", "narrow done", d, 1);
    chk(temp == 23000, "R8", "narrow temp", temp, 23000);
    chk(hum == 45000, "R8", "narrow hum", hum, 45000);
    fill(mk(8'h01, 8'h01, 8'h01, 8'h01), 0, 70000, 26000);
    repeat (10) @(negedge clk);
    chk(done && temp == 23000 && hum == 45000, "R10", "results held", temp, 23000);
  endtask

  task automatic t_threshold();
    int n; bit d;
    fill(mk(8'h2D, 8'h00, 8'h17, 8'h00), 0, 49001, 49000);
    run(81, n, d);
    chk(d && temp == 23000 && hum == 45000, "R4", "49001 is one, 49000 is zero", temp, 23000);
    fill(mk(8'h2D, 8'h00, 8'h17, 8'h00), 0, 49000, 49000);
    run(81, n, d);
    chk(d && temp == 0 && hum == 0, "R4", "all 49000 decodes as zeros", hum, 0);
  endtask

  task automatic t_sync_retry();
    int n; bit d;
    fill(mk(8'h02, 8'h8C, 8'h01, 8'h5F), 0, 70000, 26000);
    run(82, n, d);
    chk(d, "R3", "sync retry done", d, 1);
    chk(n == 43, "R3", "sync retry latency", n, 43);
    chk(hum == 65200 && temp == 35100, "R2", "offset from count 82", hum, 65200);
  endtask

  task automatic t_csum_retry();
    int n; bit d;
    fill(mk(8'h02, 8'h8C, 8'h01, 8'h5F), 0, 70000, 26000);
    run(83, n, d);
    chk(d, "R6", "checksum retry done", d, 1);
    chk(n == 84, "R6", "checksum retry latency", n, 84);
    chk(temp == 35100, "R6", "temp after retries", temp, 35100);
  endtask

  task automatic t_failures();
    int n; bit d;
    fill(mk(8'h2D, 8'h05, 8'h17, 8'h00), 0, 70000, 26000);
    run(81, n, d);
    chk(err && !done, "R9", "undecodable bytes", err, 1);
    chk(n == 41, "R9", "undecodable latency", n, 41);
    fill(mk(8'h04, 8'h01, 8'h10, 8'h00), 0, 70000, 26000);
    run(81, n, d);
    chk(err && !done, "R9", "hum byte 4 with fraction", err, 1);
    fill({mk(8'h2D, 8'h00, 8'h17, 8'h00)} ^ 40'h1, 0, 70000, 26000);
    run(81, n, d);
    chk(err && !done && n == 41, "R6", "bad checksum error", n, 41);
    run(50, n, d);
    chk(err && n == 0, "R2", "negative start offset", n, 0);
    fill(mk(8'h2D, 8'h00, 8'h17, 8'h00), 0, 70000, 26000);
    @(negedge clk);
    start = 1'b1;
    edge_cnt = CNT_W'(81);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(!err && !done, "R11", "start clears err", err, 0);
    repeat (45) @(negedge clk);
    chk(done && !err && temp == 23000, "R11", "decode after error", temp, 23000);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected below 100000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wide_pos();
    t_wide_neg();
    t_narrow_hold();
    t_threshold();
    t_sync_retry();
    t_csum_retry();
    t_failures();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule